// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes one output tile C = A·B on a fixed grid of ROWS × COLS multiply-accumulate cells. Each cell owns one element of C and keeps its running sum in place, while the operands travel through the grid. Values of A move rightward along each row, and values of B move downward along each column. One column of A and one row of B enter the grid per accepted beat, and each value is read from the edge only once.

Before the grid, row i of A and column j of B each pass through a delay line i (or j) cycles deep. As a result, the two operands that share an inner index arrive at cell (i, j) on the same cycle. A start pulse clears every sum and every pipeline stage. The caller then supplies K beats, and the last one carries a last flag. While the grid empties, the edge feeds zeros. When the final product has been added into the far corner cell, a done flag rises and the tile is read out one row per cycle, with the row index beside the data.

Operands are signed 8-bit values and sums are signed 32-bit values. A tile therefore finishes in about ROWS + K + COLS cycles after the first beat.

Top module: `sa_matmul`

## Requirements
- R1: While reset is held and just after it is released, `done` and `out_valid` are low.
- R2: A `start` pulse clears all sums and all operand pipelines, including during a run that is still loading. Only beats accepted after the latest start contribute to the result.
- R3: The drained element at row r, column j equals the sum over the accepted beats k of A[r][k]·B[k][j], using signed 8-bit operands and a signed 32-bit sum. For beat k, row i of A is `a_in[i*8 +: 8]` and column j of B is `b_in[j*8 +: 8]`.
- R4: Let edge e be the clock edge that samples the beat with `in_last` high. `done` is first high after edge e + ROWS + COLS − 1, and is low after every earlier edge of the run.
- R5: `out_valid` is high for exactly ROWS consecutive cycles, starting in the first cycle that `done` is high. In those cycles `out_row` counts 0, 1, … ROWS−1, and `out_data[j*32 +: 32]` carries element (`out_row`, j).
- R6: `done` stays high after the drain until the next `start`, and it is low in the cycle after a `start` is sampled.
- R7: A cycle with `in_valid` low while loading is a gap. It adds nothing to the result, whatever values are on `a_in` and `b_in`.
- R8: The values on `in_valid`, `in_last`, `a_in` and `b_in` have no effect when no load is in progress: before the first start, while the grid empties, during the drain, and afterwards.
- R9: A run with K = 1, where the only beat is also the last one, yields the outer product of that column and row.
- R10: The extreme products (−128·−128, −128·127, 127·127) sum correctly over many beats without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the grid and opens a new load |
| in_valid | input | 1 | Operand beat present |
| in_last | input | 1 | Marks the final beat of the load |
| a_in | input | ROWS*8 | One column of A, row i in bits i*8 +: 8 |
| b_in | input | COLS*8 | One row of B, column j in bits j*8 +: 8 |
| done | output | 1 | Tile complete, held until the next start |
| out_valid | output | 1 | Drain beat present |
| out_row | output | max(1,clog2(ROWS)) | Row index of the drain beat |
| out_data | output | COLS*32 | Row of C, column j in bits j*32 +: 32 |

## Verification
Each internal fault shows up at the ports in a specific way. A skew line of the wrong depth pairs mismatched inner indices, so the affected row or column of the drained tile holds wrong sums. A flush count that is off by one moves the rise of `done` by a cycle, and the bench measures that to the exact edge. If a sum is not cleared by start or is not frozen after completion, the next run or the garbage driven during flush and drain corrupts the data, and this is visible in the first drained row where it occurs. Faults in the row counter show up within ROWS cycles, as a wrong `out_row` or a wrong length of `out_valid`.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FLUSH,
        ST_DRAIN,
        ST_DONE
    } sa_state_e;
endpackage

// File: rtl/sa_skew.sv
// Delay line of DEPTH registers (DEPTH >= 1), cleared synchronously by clr.
module sa_skew #(
    parameter int DW    = 8,
    parameter int DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] sh_d [DEPTH];
    logic [DW-1:0] sh_q [DEPTH];

    always_comb begin
        sh_d[0] = clr ? '0 : din;
        for (int s = 1; s < DEPTH; s++) begin
            sh_d[s] = clr ? '0 : sh_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) sh_q[s] <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[DEPTH-1];
endmodule

// File: rtl/sa_cell.sv
// One multiply-accumulate site holding its own output element.
module sa_cell #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [AW-1:0] acc
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic [AW-1:0] acc_d, acc_q;

    assign prod = $signed(a) * $signed(b);

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + {{(AW-PW){prod[PW-1]}}, prod};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/sa_ctrl.sv
// Sequencer: load beats, count the flush, then step the drain row.
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          accept,
    output logic          acc_en,
    output logic          done,
    output logic          out_valid,
    output logic [RW-1:0] out_row
);
    localparam int FC = ROWS + COLS - 1;
    localparam int CW = $clog2(FC + 1) + 1;
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    typedef struct packed {
        sa_state_e     st;
        logic [CW-1:0] cnt;
        logic [RW-1:0] row;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.st  = ST_LOAD;
            c_d.cnt = '0;
            c_d.row = '0;
        end else begin
            unique case (c_q.st)
                ST_LOAD: begin
                    if (in_valid && in_last) begin
                        c_d.st  = ST_FLUSH;
                        c_d.cnt = CW'(1);
                    end
                end
                ST_FLUSH: begin
                    if (c_q.cnt == CW'(FC)) begin
                        c_d.st  = ST_DRAIN;
                        c_d.row = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + CW'(1);
                    end
                end
                ST_DRAIN: begin
                    if (c_q.row == LAST_ROW) c_d.st = ST_DONE;
                    else c_d.row = c_q.row + RW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cnt: '0, row: '0};
        else        c_q <= c_d;
    end

    assign accept    = (c_q.st == ST_LOAD) && in_valid && !start;
    assign acc_en    = (c_q.st == ST_LOAD) || (c_q.st == ST_FLUSH);
    assign done      = (c_q.st == ST_DRAIN) || (c_q.st == ST_DONE);
    assign out_valid = (c_q.st == ST_DRAIN);
    assign out_row   = c_q.row;
endmodule

// File: rtl/sa_matmul.sv
module sa_matmul #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8,
    parameter int AW   = 32,
    parameter int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               in_valid,
    input  logic               in_last,
    input  logic [ROWS*DW-1:0] a_in,
    input  logic [COLS*DW-1:0] b_in,
    output logic               done,
    output logic               out_valid,
    output logic [RW-1:0]      out_row,
    output logic [COLS*AW-1:0] out_data
);
    logic accept, acc_en;

    logic [DW-1:0] a_edge [ROWS];
    logic [DW-1:0] b_edge [COLS];
    logic [DW-1:0] a_sk   [ROWS];
    logic [DW-1:0] b_sk   [COLS];

    // operand seen by cell (i, j) this cycle
    logic [DW-1:0] a_d [ROWS][COLS];
    logic [DW-1:0] a_q [ROWS][COLS];
    logic [DW-1:0] b_d [ROWS][COLS];
    logic [DW-1:0] b_q [ROWS][COLS];
    logic [AW-1:0] acc [ROWS][COLS];

    sa_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_last(in_last),
        .accept(accept), .acc_en(acc_en),
        .done(done), .out_valid(out_valid), .out_row(out_row)
    );

    // zero injection outside accepted beats
    always_comb begin
        for (int i = 0; i < ROWS; i++) a_edge[i] = accept ? a_in[i*DW +: DW] : '0;
        for (int j = 0; j < COLS; j++) b_edge[j] = accept ? b_in[j*DW +: DW] : '0;
    end

    // edge skew: row i and column j delayed by their index
    for (genvar i = 0; i < ROWS; i++) begin : g_askew
        if (i == 0) begin : g_none
            assign a_sk[i] = a_edge[i];
        end else begin : g_line
            sa_skew #(.DW(DW), .DEPTH(i)) u_skew (
                .clk(clk), .rst_n(rst_n), .clr(start),
                .din(a_edge[i]), .dout(a_sk[i])
            );
        end
    end

    for (genvar j = 0; j < COLS; j++) begin : g_bskew
        if (j == 0) begin : g_none
            assign b_sk[j] = b_edge[j];
        end else begin : g_line
            sa_skew #(.DW(DW), .DEPTH(j)) u_skew (
                .clk(clk), .rst_n(rst_n), .clr(start),
                .din(b_edge[j]), .dout(b_sk[j])
            );
        end
    end

    // operand movement: A one cell right, B one cell down, per cycle
    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            a_d[i][0] = start ? '0 : a_sk[i];
            for (int j = 1; j < COLS; j++) a_d[i][j] = start ? '0 : a_q[i][j-1];
        end
        for (int j = 0; j < COLS; j++) begin
            b_d[0][j] = start ? '0 : b_sk[j];
            for (int i = 1; i < ROWS; i++) b_d[i][j] = start ? '0 : b_q[i-1][j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                for (int j = 0; j < COLS; j++) begin
                    a_q[i][j] <= '0;
                    b_q[i][j] <= '0;
                end
            end
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            sa_cell #(.DW(DW), .AW(AW)) u_cell (
                .clk(clk), .rst_n(rst_n), .clr(start), .en(acc_en),
                .a(a_q[i][j]), .b(b_q[i][j]), .acc(acc[i][j])
            );
        end
    end

    always_comb begin
        for (int j = 0; j < COLS; j++) out_data[j*AW +: AW] = acc[out_row][j];
    end
endmodule

// File: rtl/sa_matmul_chk.sv
module sa_matmul_chk #(
    parameter int ROWS = 4,
    parameter int RW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          out_valid,
    input logic [RW-1:0] out_row
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    // R6
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5
    drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> done);

    // R5
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (out_valid && out_row == '0));

    // R5
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row != LAST_ROW && !start) |=>
        (out_valid && out_row == RW'($past(out_row) + 1'b1)));

    // R5
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row == LAST_ROW && !start) |=> !out_valid);
endmodule

bind sa_matmul sa_matmul_chk #(.ROWS(ROWS), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .out_valid(out_valid), .out_row(out_row)
);

// File: tb/sa_matmul_tb.sv
module sa_matmul_tb;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int KMAX = 20;
    localparam int RW   = 2;
    localparam int NCASE = 8;
    // fields: K, seed, mode (0 random, 1 all -128, 2 A=-128 B=127, 3 all 127), gaps, abort
    localparam int CASES [NCASE][5] = '{
        '{4,  11,   0, 0, 0},
        '{1,  5,    0, 0, 0},
        '{16, 77,   1, 0, 0},
        '{16, 3,    2, 0, 0},
        '{9,  21,   0, 1, 0},
        '{6,  99,   0, 0, 1},
        '{20, 1234, 0, 0, 0},
        '{2,  8,    3, 0, 0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic in_valid = 0;
    logic in_last = 0;
    logic [ROWS*8-1:0] a_in = '0;
    logic [COLS*8-1:0] b_in = '0;
    logic done, out_valid;
    logic [RW-1:0] out_row;
    logic [COLS*32-1:0] out_data;

    int total = 0;
    int bad = 0;
    int unsigned lcg = 1;
    int ma [ROWS][KMAX];
    int mb [KMAX][COLS];
    int mc [ROWS][COLS];

    always #2 clk = ~clk;

    sa_matmul #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_last(in_last), .a_in(a_in), .b_in(b_in), .done(done),
        .out_valid(out_valid), .out_row(out_row), .out_data(out_data)
    );

    function automatic int rnd8();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) & 32'hff) - 128;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic garbage(input bit vld);
        in_valid = vld;
        in_last  = 1'b1;
        for (int i = 0; i < ROWS; i++) a_in[i*8 +: 8] = 8'(rnd8());
        for (int j = 0; j < COLS; j++) b_in[j*8 +: 8] = 8'(rnd8());
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R6 done low after start", int'(done), 0);
    endtask

    task automatic run_case(input int k, input int seed, input int mode,
                            input int gaps, input int abort_first);
        int n;
        lcg = seed;
        for (int i = 0; i < ROWS; i++)
            for (int kk = 0; kk < k; kk++)
                ma[i][kk] = (mode == 0) ? rnd8() : (mode == 3) ? 127 : -128;
        for (int kk = 0; kk < k; kk++)
            for (int j = 0; j < COLS; j++)
                mb[kk][j] = (mode == 0) ? rnd8() : (mode == 1) ? -128 : 127;
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                mc[i][j] = 0;
                for (int kk = 0; kk < k; kk++) mc[i][j] += ma[i][kk] * mb[kk][j];
            end

        if (abort_first != 0) begin
            // R2: partial load that a second start must discard
            pulse_start();
            for (int s = 0; s < 3; s++) begin
                in_valid = 1'b1;
                in_last  = 1'b0;
                a_in = {ROWS{8'h80}};
                b_in = {COLS{8'h80}};
                @(negedge clk);
            end
        end
        pulse_start();
        for (int kk = 0; kk < k; kk++) begin
            if (gaps != 0 && (kk % 2) == 1) begin
                garbage(1'b0);   // R7 gap with live data
                in_last = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_last  = (kk == k - 1);
            for (int i = 0; i < ROWS; i++) a_in[i*8 +: 8] = 8'(ma[i][kk]);
            for (int j = 0; j < COLS; j++) b_in[j*8 +: 8] = 8'(mb[kk][j]);
            if (kk == k - 1) begin
                @(posedge clk);
                #1;
            end else begin
                @(negedge clk);
            end
        end

        // R4 count edges to done; R8 garbage offered while emptying
        n = 0;
        while (done !== 1'b1 && n < 40) begin
            garbage(1'b1);
            @(posedge clk);
            #1;
            n++;
        end
        check(n == ROWS + COLS - 1, "R4 done latency", n, ROWS + COLS - 1);

        // R5 drain order and R3 data, garbage still driven (R8)
        for (int r = 0; r < ROWS; r++) begin
            check(out_valid == 1'b1, "R5 out_valid in drain", int'(out_valid), 1);
            check(int'(out_row) == r, "R5 out_row", int'(out_row), r);
            for (int j = 0; j < COLS; j++)
                check($signed(out_data[j*32 +: 32]) == mc[r][j], "R3 R8 R9 R10 element",
                      $signed(out_data[j*32 +: 32]), mc[r][j]);
            garbage(1'b1);
            @(posedge clk);
            #1;
        end
        check(out_valid == 1'b0, "R5 drain length", int'(out_valid), 0);
        check(done == 1'b1, "R6 done held", int'(done), 1);
        @(posedge clk);
        #1;
        check(done == 1'b1, "R6 done still held", int'(done), 1);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && out_valid == 1'b0, "R1 outputs in reset",
              int'({done, out_valid}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: stimulus before any start
        for (int s = 0; s < 4; s++) begin
            garbage(1'b1);
            @(negedge clk);
            check(done == 1'b0 && out_valid == 1'b0, "R1 R8 idle outputs",
                  int'({done, out_valid}), 0);
        end
        in_valid = 1'b0;
        for (int c = 0; c < NCASE; c++) begin
            run_case(CASES[c][0], CASES[c][1], CASES[c][2], CASES[c][3], CASES[c][4]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule